// File: doc/BRIEF.md
# Vector-Programmed Word Packer

The block sits between a 32-bit word FIFO and a serial engine that moves data in chunks of one to eight bits. Instead of a fixed byte order, a short list of packing vectors selects which bit field of each word forms each chunk, and in which order. The transmit path unpacks each incoming word into a run of chunks. The receive path builds words back up from incoming chunks. Each direction has its own vector list.

Software loads each direction's list through two 32-bit configuration registers. Each register holds two 10-bit vectors. A one-bit granularity register selects half-word operation. In that mode, each list is applied twice per word, and the second pass is shifted up by 16 bit positions. Both data paths use valid/ready handshakes. Every chunk carries its length minus one.

Top module: `vec_word_packer`

## Requirements
- R1: After reset, both vector lists hold four 8-bit vectors, upward, with start indices 0, 8, 16 and 24, and the stop flag on the last vector. Granularity is 0. No output is valid. Both input-side ready outputs are high.
- R2: A vector is encoded as start index [9:5], MSB-first flag [4], length minus one [3:1] and stop flag [0]. The write addresses are: 0 for transmit vectors 0/1, 1 for transmit vectors 2/3, 2 for receive vectors 0/1, 3 for receive vectors 2/3, and 4 for granularity (bit 0). The lower-numbered vector of each pair sits in data bits [9:0], the other in bits [19:10].
- R3: With the MSB-first flag clear, transmit chunk bit b equals word bit (start+b), for b up to the length. The chunk is right-aligned, and its bits above the length are zero.
- R4: With the MSB-first flag set, the chunk covers word bits (start-len) up to start. Chunk bit 0 is taken from word bit (start-len).
- R5: The vector that carries the stop flag is the last one applied to a word. The next word starts again at vector 0. The chunk length output equals that vector's length minus one.
- R6: If no vector carries the stop flag, vector 3 is the last one.
- R7: With granularity 1, the list runs a second time per word, with 16 added to every start index, before the word is finished.
- R8: On receive, each chunk's low (len+1) bits are written into the word at the positions its vector names, and chunk bits above the length are ignored. The word is output after the last vector, and bits that no vector covers read as zero.
- R9: Writing one direction's configuration leaves the other direction's list unchanged.
- R10: While a downstream ready input is low, the pending chunk or word stays valid and stable, and no new input is accepted once the path is full.
- R11: Bit indices wrap modulo 32, both when the shifted start index overflows and when start-len underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| tx_word_i | input | 32 | Transmit word from FIFO |
| tx_word_valid_i | input | 1 | Transmit word valid |
| tx_word_ready_o | output | 1 | Transmit word accepted |
| tx_chunk_o | output | 8 | Transmit chunk, right-aligned |
| tx_chunk_len_o | output | 3 | Transmit chunk length minus one |
| tx_chunk_valid_o | output | 1 | Transmit chunk valid |
| tx_chunk_ready_i | input | 1 | Serial side takes the chunk |
| rx_chunk_i | input | 8 | Receive chunk, right-aligned |
| rx_chunk_valid_i | input | 1 | Receive chunk valid |
| rx_chunk_ready_o | output | 1 | Receive chunk accepted |
| rx_chunk_len_o | output | 3 | Expected length minus one for the next receive chunk |
| rx_word_o | output | 32 | Assembled receive word |
| rx_word_valid_o | output | 1 | Receive word valid |
| rx_word_ready_i | input | 1 | FIFO takes the word |

## Verification
Several vector lists are run through both paths:
- The reset byte order separates a correct byte lane from a swapped one.
- A two-vector MSB-first list with an early stop shows both the direction arithmetic and the early restart.
- Four stop-less 4-bit vectors show that vector 3 ends the word by default.
- A half-word list with granularity 1 shows that the second pass is offset.
- A wrapping MSB-first vector and a single-bit vector at index 31 probe the modulo-32 corner cases.

Receive chunks are sent with garbage above their length, so any leak of those bits shows up in the word. Stall phases and a transmit-only reconfiguration separate backpressure handling from cross-talk between the two configurations.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WP_IDX_W   = 5;
  localparam int WP_LEN_W   = 3;
  localparam int WP_VEC_W   = 10;
  localparam int WP_NUM_VEC = 4;
  // reset lists: bytes 0..3 upward, stop on vector 3
  localparam logic [19:0] WP_RST_LO = 20'h4380E;
  localparam logic [19:0] WP_RST_HI = 20'hC3E0E;

  typedef struct packed {
    logic [WP_IDX_W-1:0] start;
    logic                msb_first;
    logic [WP_LEN_W-1:0] len_m1;
    logic                stop;
  } wp_vec_t;
endpackage

// File: rtl/wp_cfg.sv
module wp_cfg
  import wp_pkg::*;
#(
  parameter int NUM_VEC = WP_NUM_VEC,
  parameter int VEC_W   = WP_VEC_W,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output wp_vec_t           tx_vecs_o [NUM_VEC],
  output wp_vec_t           rx_vecs_o [NUM_VEC],
  output logic              gran_o
);
  localparam int VPR    = 2;
  localparam int PAIR_W = VPR * VEC_W;
  localparam int REGS_D = NUM_VEC / VPR;
  localparam int NREG   = 2 * REGS_D;

  logic [PAIR_W-1:0] cfg_q [NREG];
  logic              gran_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) cfg_q[r] <= (r % 2 == 0) ? WP_RST_LO : WP_RST_HI;
      gran_q <= 1'b0;
    end else if (we_i) begin
      if (int'(addr_i) < NREG) cfg_q[int'(addr_i)] <= wdata_i[PAIR_W-1:0];
      else if (int'(addr_i) == NREG) gran_q <= wdata_i[0];
    end
  end

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
    assign tx_vecs_o[k] = cfg_q[k/VPR][(k%VPR)*VEC_W +: VEC_W];
    assign rx_vecs_o[k] = cfg_q[REGS_D + k/VPR][(k%VPR)*VEC_W +: VEC_W];
  end

  assign gran_o = gran_q;
endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
#(
  parameter int NUM_VEC = WP_NUM_VEC,
  parameter int IDX_W   = WP_IDX_W,
  parameter int LEN_W   = WP_LEN_W,
  parameter int WORD_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wp_vec_t          vecs_i [NUM_VEC],
  input  logic             gran_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] lo_o,
  output logic [LEN_W-1:0] len_m1_o,
  output logic             last_o
);
  localparam int VSEL_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int HALF   = WORD_W / 2;

  logic [VSEL_W-1:0] idx_q;
  logic              pass_q;
  wp_vec_t           cur;
  logic              last_vec;
  logic [IDX_W-1:0]  off;

  assign cur      = vecs_i[idx_q];
  assign last_vec = cur.stop || (idx_q == VSEL_W'(NUM_VEC-1));
  assign last_o   = last_vec && (pass_q || !gran_i);
  assign off      = pass_q ? IDX_W'(HALF) : '0;
  assign lo_o     = IDX_W'(cur.start) + off - (cur.msb_first ? IDX_W'(cur.len_m1) : '0);
  assign len_m1_o = cur.len_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pass_q <= 1'b0;
    end else if (step_i) begin
      if (last_o) begin
        idx_q  <= '0;
        pass_q <= 1'b0;
      end else if (last_vec) begin
        idx_q  <= '0;
        pass_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && last_o |=> (idx_q == '0) && !pass_q);
  a_r7_second_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && last_vec && !last_o |=> pass_q && (idx_q == '0));
endmodule

// File: rtl/wp_unpack.sv
module wp_unpack #(
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 8,
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   lo_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic               last_i,
  output logic               step_o,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  output logic [CHUNK_W-1:0] chunk_o,
  output logic [LEN_W-1:0]   len_m1_o,
  output logic               valid_o,
  input  logic               ready_i
);
  logic [WORD_W-1:0] word_q;
  logic              hold_q;

  assign step_o       = hold_q && ready_i;
  assign word_ready_o = !hold_q || (step_o && last_i);
  assign valid_o      = hold_q;
  assign len_m1_o     = len_m1_i;

  always_comb begin
    chunk_o = '0;
    for (int b = 0; b < CHUNK_W; b++) begin
      if (b <= int'(len_m1_i)) chunk_o[b] = word_q[IDX_W'(lo_i + IDX_W'(b))];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      hold_q <= 1'b0;
    end else if (word_valid_i && word_ready_o) begin
      word_q <= word_i;
      hold_q <= 1'b1;
    end else if (step_o && last_i) begin
      hold_q <= 1'b0;
    end
  end

  a_r10_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(chunk_o) && $stable(len_m1_o));
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((16'(chunk_o) >> (int'(len_m1_o) + 1)) == 16'd0));
  a_r10_tx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |=> valid_o);
endmodule

// File: rtl/wp_pack.sv
module wp_pack #(
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 8,
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   lo_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic               last_i,
  output logic               step_o,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               chunk_valid_i,
  output logic               chunk_ready_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_valid_o,
  input  logic               word_ready_i
);
  logic [WORD_W-1:0] acc_q, word_q, placed;
  logic              out_q;

  assign chunk_ready_o = !out_q || word_ready_i;
  assign step_o        = chunk_valid_i && chunk_ready_o;
  assign word_o        = word_q;
  assign word_valid_o  = out_q;

  always_comb begin
    placed = acc_q;
    for (int b = 0; b < CHUNK_W; b++) begin
      if (b <= int'(len_m1_i)) placed[IDX_W'(lo_i + IDX_W'(b))] = chunk_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      word_q <= '0;
      out_q  <= 1'b0;
    end else begin
      if (step_o) begin
        if (last_i) begin
          word_q <= placed;
          acc_q  <= '0;
        end else begin
          acc_q <= placed;
        end
      end
      if (step_o && last_i) out_q <= 1'b1;
      else if (word_ready_i) out_q <= 1'b0;
    end
  end

  a_r10_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));
  a_r8_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && last_i |=> word_valid_o);
  a_r10_rx_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |-> !chunk_ready_o);
endmodule

// File: rtl/vec_word_packer.sv
module vec_word_packer
  import wp_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 8,
  parameter int NUM_VEC = WP_NUM_VEC,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic [WORD_W-1:0]  tx_word_i,
  input  logic               tx_word_valid_i,
  output logic               tx_word_ready_o,
  output logic [CHUNK_W-1:0] tx_chunk_o,
  output logic [WP_LEN_W-1:0] tx_chunk_len_o,
  output logic               tx_chunk_valid_o,
  input  logic               tx_chunk_ready_i,
  input  logic [CHUNK_W-1:0] rx_chunk_i,
  input  logic               rx_chunk_valid_i,
  output logic               rx_chunk_ready_o,
  output logic [WP_LEN_W-1:0] rx_chunk_len_o,
  output logic [WORD_W-1:0]  rx_word_o,
  output logic               rx_word_valid_o,
  input  logic               rx_word_ready_i
);
  localparam int IDX_W = $clog2(WORD_W);

  wp_vec_t tx_vecs [NUM_VEC];
  wp_vec_t rx_vecs [NUM_VEC];
  logic    gran;

  logic [IDX_W-1:0]    tx_lo, rx_lo;
  logic [WP_LEN_W-1:0] tx_len, rx_len;
  logic                tx_last, rx_last, tx_step, rx_step;

  wp_cfg #(.NUM_VEC(NUM_VEC), .VEC_W(WP_VEC_W), .ADDR_W(ADDR_W), .DATA_W(32)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .tx_vecs_o(tx_vecs), .rx_vecs_o(rx_vecs), .gran_o(gran));

  wp_seq #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .LEN_W(WP_LEN_W), .WORD_W(WORD_W)) u_tx_seq (
    .clk_i, .rst_ni, .vecs_i(tx_vecs), .gran_i(gran), .step_i(tx_step),
    .lo_o(tx_lo), .len_m1_o(tx_len), .last_o(tx_last));

  wp_seq #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .LEN_W(WP_LEN_W), .WORD_W(WORD_W)) u_rx_seq (
    .clk_i, .rst_ni, .vecs_i(rx_vecs), .gran_i(gran), .step_i(rx_step),
    .lo_o(rx_lo), .len_m1_o(rx_len), .last_o(rx_last));

  wp_unpack #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W), .IDX_W(IDX_W), .LEN_W(WP_LEN_W)) u_unpack (
    .clk_i, .rst_ni, .lo_i(tx_lo), .len_m1_i(tx_len), .last_i(tx_last), .step_o(tx_step),
    .word_i(tx_word_i), .word_valid_i(tx_word_valid_i), .word_ready_o(tx_word_ready_o),
    .chunk_o(tx_chunk_o), .len_m1_o(tx_chunk_len_o), .valid_o(tx_chunk_valid_o),
    .ready_i(tx_chunk_ready_i));

  wp_pack #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W), .IDX_W(IDX_W), .LEN_W(WP_LEN_W)) u_pack (
    .clk_i, .rst_ni, .lo_i(rx_lo), .len_m1_i(rx_len), .last_i(rx_last), .step_o(rx_step),
    .chunk_i(rx_chunk_i), .chunk_valid_i(rx_chunk_valid_i), .chunk_ready_o(rx_chunk_ready_o),
    .word_o(rx_word_o), .word_valid_o(rx_word_valid_o), .word_ready_i(rx_word_ready_i));

  assign rx_chunk_len_o = rx_len;
endmodule

// File: tb/vec_word_packer_test.sv
module vec_word_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] tx_word = '0;
  logic        tx_word_valid = 1'b0;
  logic        tx_word_ready;
  logic [7:0]  tx_chunk;
  logic [2:0]  tx_len;
  logic        tx_chunk_valid;
  logic        tx_chunk_ready = 1'b1;
  logic [7:0]  rx_chunk = '0;
  logic        rx_chunk_valid = 1'b0;
  logic        rx_chunk_ready;
  logic [2:0]  rx_len;
  logic [31:0] rx_word;
  logic        rx_word_valid;
  logic        rx_word_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_word_packer uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .tx_word_i(tx_word), .tx_word_valid_i(tx_word_valid), .tx_word_ready_o(tx_word_ready),
    .tx_chunk_o(tx_chunk), .tx_chunk_len_o(tx_len), .tx_chunk_valid_o(tx_chunk_valid),
    .tx_chunk_ready_i(tx_chunk_ready), .rx_chunk_i(rx_chunk), .rx_chunk_valid_i(rx_chunk_valid),
    .rx_chunk_ready_o(rx_chunk_ready), .rx_chunk_len_o(rx_len), .rx_word_o(rx_word),
    .rx_word_valid_o(rx_word_valid), .rx_word_ready_i(rx_word_ready));

  typedef struct packed {
    logic [31:0] c0;
    logic [31:0] c1;
    logic        g;
    logic [31:0] w;
    logic [3:0]  n;
    logic [63:0] ch;   // chunk i at [8i+7:8i]
    logic [23:0] ln;   // len-1 of chunk i at [3i+2:3i]
    logic [31:0] rxw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    // R1 R3: reset byte list
    '{32'h0004380E, 32'h000C3E0E, 1'b0, 32'hA1B2C3D4, 4'd4, 64'hA1B2C3D4, 24'o77777777, 32'hA1B2C3D4},
    // R2 R4 R5: two MSB-first bytes, stop on vector 1
    '{32'h0003FDFE, 32'h0, 1'b0, 32'h1234BEEF, 4'd2, 64'hEFBE, 24'o77777777, 32'h0000BEEF},
    // R6 R8: four nibbles, no stop flag
    '{32'h00021806, 32'h00061906, 1'b0, 32'hFFFF5A3C, 4'd4, 64'h050A030C, 24'o33333333, 32'h00005A3C},
    // R7: half-word list, granularity 1
    '{32'h00043C0E, 32'h0, 1'b1, 32'h11223344, 4'd4, 64'h11223344, 24'o77777777, 32'h11223344},
    // R11: MSB-first vector wrapping below bit 0
    '{32'h0000005F, 32'h0, 1'b0, 32'h80000005, 4'd1, 64'hB0, 24'o77777777, 32'h80000005},
    // R3 R8: single bit at index 31
    '{32'h000003E1, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd1, 64'h01, 24'o0, 32'h80000000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    tx_word_valid = 1'b1; tx_word = w;
    while (!tx_word_ready) @(negedge clk);
    @(negedge clk);
    tx_word_valid = 1'b0;
  endtask

  task automatic get_chunks(input int n, input logic [63:0] ch, input logic [23:0] ln, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tx_chunk_valid) @(negedge clk);
      chk(tx_chunk == ch[8*i +: 8], {req, " tx chunk"}, 32'(tx_chunk), 32'(ch[8*i +: 8]));
      chk(tx_len == ln[3*i +: 3], {req, " R5 tx len"}, 32'(tx_len), 32'(ln[3*i +: 3]));
    end
  endtask

  // garbage above each chunk's length must be ignored (R8)
  task automatic send_chunks(input int n, input logic [63:0] ch, input logic [23:0] ln);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_chunk_valid = 1'b1;
      rx_chunk = ch[8*i +: 8] | (8'hFF << (int'(ln[3*i +: 3]) + 1));
      while (!rx_chunk_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_chunk_valid = 1'b0;
  endtask

  task automatic get_word(input logic [31:0] exp, input string req);
    @(negedge clk);
    while (!rx_word_valid) @(negedge clk);
    chk(rx_word == exp, {req, " R8 rx word"}, rx_word, exp);
  endtask

  task automatic run_entry(input int e, input bit wr);
    vec_t t = TBL[e];
    if (wr) begin
      cfg_write(3'd0, t.c0);
      cfg_write(3'd1, t.c1);
      cfg_write(3'd2, t.c0);
      cfg_write(3'd3, t.c1);
      cfg_write(3'd4, 32'(t.g));
    end
    fork
      send_word(t.w);
      get_chunks(int'(t.n), t.ch, t.ln, $sformatf("entry%0d R3 R4 R6 R7 R11", e));
    join
    fork
      send_chunks(int'(t.n), t.ch, t.ln);
      get_word(t.rxw, $sformatf("entry%0d R7 R11", e));
    join
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(!tx_chunk_valid, "R1 tx valid", 32'(tx_chunk_valid), 0);
    chk(!rx_word_valid, "R1 rx valid", 32'(rx_word_valid), 0);
    chk(tx_word_ready, "R1 tx word ready", 32'(tx_word_ready), 1);
    chk(rx_chunk_ready, "R1 rx chunk ready", 32'(rx_chunk_ready), 1);
    chk(rx_len == 3'd7, "R1 rx len", 32'(rx_len), 7);
    rst_n = 1'b1;
    // R1: default lists without any write
    run_entry(0, 1'b0);

    for (int e = 0; e < NV; e++) run_entry(e, 1'b1);

    cfg_write(3'd0, TBL[0].c0); cfg_write(3'd1, TBL[0].c1);
    cfg_write(3'd2, TBL[0].c0); cfg_write(3'd3, TBL[0].c1);
    cfg_write(3'd4, 32'd0);

    // R10: transmit stall
    tx_chunk_ready = 1'b0;
    send_word(32'hCAFEF00D);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_chunk_valid && tx_chunk == 8'h0D, "R10 tx stall chunk", 32'(tx_chunk), 32'h0D);
      chk(!tx_word_ready, "R10 tx full", 32'(tx_word_ready), 0);
    end
    tx_chunk_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(tx_chunk_valid && tx_chunk == 8'(32'hCAFEF00D >> (8*i)), "R10 tx after stall",
          32'(tx_chunk), 32'hCAFEF00D >> (8*i));
      @(negedge clk);
    end

    // R10: receive stall
    rx_word_ready = 1'b0;
    send_chunks(4, 64'hCAFEF00D, 24'o77777777);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rx_word_valid && rx_word == 32'hCAFEF00D, "R10 rx stall word", rx_word, 32'hCAFEF00D);
      chk(!rx_chunk_ready, "R10 rx full", 32'(rx_chunk_ready), 0);
    end
    rx_word_ready = 1'b1;
    @(negedge clk);
    chk(!rx_word_valid, "R10 rx popped", 32'(rx_word_valid), 0);

    // R9: transmit-only rewrite leaves receive bytes
    cfg_write(3'd0, TBL[4].c0);
    cfg_write(3'd1, TBL[4].c1);
    fork
      send_word(32'h80000005);
      get_chunks(1, 64'hB0, 24'o7, "R9 R11");
    join
    fork
      send_chunks(4, 64'h00000000CAFEF00D, 24'o77777777);
      get_word(32'hCAFEF00D, "R9");
    join

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule